// File: doc/BRIEF.md
# Two-Wire Slave Front End for a 12-bit DAC Control Word

This block is a two-wire (I2C-compatible) slave that sits in the system clock domain and owns the 16-bit control word of a voltage-output DAC. It oversamples the serial clock and data lines, removes short glitches, and detects bus conditions. It pulls the data line low through an open-drain enable. A bus master can write the word as two bytes, high byte first. It can stream several words under one address. It can also read the word back as two bytes.

The block answers to its own 7-bit address, which comes from an input. It also answers to a fixed broadcast address, so that many converters on one bus can load the same word together. It recognises the high-speed master-code preamble and raises a high-speed flag, which holds until a Stop. The converter side gets the 12-bit code and the two power-down mode bits. It also gets a one-cycle strobe each time a word is committed. The first time the block acknowledges its own (non-broadcast) address, it emits a one-cycle pulse so that external address-selection logic can freeze its choice.

Top module: `i2c_dac_slave`

## Requirements
- R1: When the 7-bit address plus R/W bit received after a Start matches `own_addr`, the block pulls SDA low during the following acknowledge bit. On any other non-broadcast address it leaves SDA released. It then ignores every byte until the next Start or Stop, and the outputs do not change.
- R2: In a write, the high byte and the low byte are each acknowledged. The control word, `dac_code` and `dac_pd` change only on the SCL rising edge inside the acknowledge bit that follows the low byte. At that same clock `dac_update` is high, for exactly one cycle. After the high byte alone, nothing changes.
- R3: After a committed word, further high/low byte pairs sent without re-addressing are each committed in turn, until a Stop or Repeated Start.
- R4: In a read (R/W bit = 1), the block shifts out the high byte and then the low byte, MSB first. After the master acknowledges the high byte, the low byte follows. After the master's NACK on the low byte, SDA stays released.
- R5: In the control word, bits 15:14 are always stored and read as zero, whatever value is written. Bits 13:12 are the power-down mode and appear on `dac_pd`. Bits 11:0 are the straight-binary code and appear on `dac_code`.
- R6: The broadcast address 7'b1001000 with R/W = 0 is acknowledged, and words written under it are committed exactly like words written under `own_addr`.
- R7: The broadcast address with R/W = 1 is not acknowledged, and no read data is driven.
- R8: After reset the control word is 16'h0000, `sda_oe` is low and `hs_mode` is low. While the power-down field is nonzero, the 12-bit code is kept unchanged and can be read back.
- R9: A first byte after a Start whose upper five bits are 5'b00001 (the high-speed master code) is not acknowledged. The next Repeated Start then sets `hs_mode`. Later Repeated Starts keep it set, and only a Stop clears it.
- R10: A Start or Stop that arrives in the middle of a byte abandons that byte, and nothing is committed.
- R11: `addr_lock` pulses high for one cycle at the first acknowledge of `own_addr`, and never again until reset. The broadcast address does not produce it.
- R12: A low pulse on SCL that lasts one system clock is filtered out and does not disturb a transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| own_addr | input | 7 | Device address to answer to |
| sda_oe | output | 1 | When high, the pad pulls SDA low |
| dac_code | output | 12 | Committed output code |
| dac_pd | output | 2 | Committed power-down mode, 0 = normal |
| dac_update | output | 1 | One-cycle strobe on each commit |
| hs_mode | output | 1 | High-speed mode flag |
| addr_lock | output | 1 | One-cycle pulse on the first own-address acknowledge |

## Verification
The assertions watch, on every cycle, that the converter outputs move only together with the update strobe. They also check that the strobe lasts one cycle and falls inside an acknowledge that the block itself is driving, and that the lock pulse is single and occurs at most once. The bench scenarios are needed to show the protocol behaviour. These are the address decode and broadcast handling, streaming of several words, read-back of the stored word with its forced-zero top bits, the abort on a mid-byte Start, the high-speed flag sequence, and the rejection of a one-clock SCL glitch.

// File: rtl/i2cdac_pkg.sv
package i2cdac_pkg;

  localparam int BYTE_W = 8;
  localparam int WORD_W = 16;
  localparam int CODE_W = 12;
  localparam int PD_W   = 2;
  localparam int BIT_CNT_W = $clog2(BYTE_W + 1);

  localparam logic [6:0] BCAST_ADDR  = 7'b1001000;
  localparam logic [4:0] HS_CODE_TOP = 5'b00001;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_MACK,
    ST_SKIP
  } eng_state_t;

endpackage

// File: rtl/i2cdac_deglitch.sv
module i2cdac_deglitch #(
  parameter int SYNC_STAGES = 2,
  parameter int VOTE_TAPS   = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic raw,
  output logic clean
);
  localparam int CW = $clog2(VOTE_TAPS + 1);
  localparam logic [CW-1:0] HALF = CW'(VOTE_TAPS / 2);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [VOTE_TAPS-1:0]   taps_q;
  logic [CW-1:0]          ones;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '1;
      taps_q <= '1;
      clean  <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], raw};
      taps_q <= {taps_q[VOTE_TAPS-2:0], sync_q[SYNC_STAGES-1]};
      clean  <= (ones > HALF);
    end
  end

  always_comb begin
    ones = '0;
    for (int i = 0; i < VOTE_TAPS; i++) begin
      ones = ones + {{(CW-1){1'b0}}, taps_q[i]};
    end
  end

endmodule

// File: rtl/i2cdac_bus_events.sv
module i2cdac_bus_events (
  input  logic clk,
  input  logic rst,
  input  logic scl,
  input  logic sda,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl;
      sda_q <= sda;
    end
  end

  assign scl_rise  = scl & ~scl_q;
  assign scl_fall  = ~scl & scl_q;
  assign start_det = scl & scl_q & sda_q & ~sda;
  assign stop_det  = scl & scl_q & ~sda_q & sda;

endmodule

// File: rtl/i2cdac_engine.sv
module i2cdac_engine
  import i2cdac_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              sda_in,
  input  logic [6:0]        own_addr,
  output logic              sda_oe,
  output logic [CODE_W-1:0] code,
  output logic [PD_W-1:0]   pd,
  output logic              update,
  output logic              hs_flag,
  output logic              lock_pulse
);
  localparam int HI_KEEP = WORD_W - BYTE_W - 2;

  eng_state_t            state;
  logic [BIT_CNT_W-1:0]  bitcnt;
  logic [BYTE_W-1:0]     shreg;
  logic [HI_KEEP-1:0]    hi_q;
  logic [WORD_W-1:0]     word_q;
  logic [WORD_W-1:0]     tx_q;
  logic                  rw_q, lo_phase, mack_ok, hs_pend, locked;

  wire byte_done = scl_fall && (bitcnt == BIT_CNT_W'(BYTE_W));

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      bitcnt     <= '0;
      shreg      <= '0;
      hi_q       <= '0;
      word_q     <= '0;
      tx_q       <= '0;
      rw_q       <= 1'b0;
      lo_phase   <= 1'b0;
      mack_ok    <= 1'b0;
      hs_pend    <= 1'b0;
      hs_flag    <= 1'b0;
      locked     <= 1'b0;
      sda_oe     <= 1'b0;
      update     <= 1'b0;
      lock_pulse <= 1'b0;
    end else begin
      update     <= 1'b0;
      lock_pulse <= 1'b0;
      if (stop_det) begin
        state   <= ST_IDLE;
        sda_oe  <= 1'b0;
        hs_flag <= 1'b0;
        hs_pend <= 1'b0;
      end else if (start_det) begin
        state  <= ST_ADDR;
        bitcnt <= '0;
        sda_oe <= 1'b0;
        if (hs_pend) begin
          hs_flag <= 1'b1;
          hs_pend <= 1'b0;
        end
      end else begin
        case (state)
          ST_ADDR: begin
            if (scl_rise) begin
              shreg  <= {shreg[BYTE_W-2:0], sda_in};
              bitcnt <= bitcnt + 1'b1;
            end else if (byte_done) begin
              if (shreg[7:3] == HS_CODE_TOP) begin
                hs_pend <= 1'b1;
                state   <= ST_SKIP;
              end else if (shreg[7:1] == own_addr) begin
                sda_oe <= 1'b1;
                rw_q   <= shreg[0];
                state  <= ST_ADDR_ACK;
                if (!locked) begin
                  locked     <= 1'b1;
                  lock_pulse <= 1'b1;
                end
              end else if (shreg[7:1] == BCAST_ADDR && !shreg[0]) begin
                sda_oe <= 1'b1;
                rw_q   <= 1'b0;
                state  <= ST_ADDR_ACK;
              end else begin
                state <= ST_SKIP;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (scl_fall) begin
              bitcnt   <= '0;
              lo_phase <= 1'b0;
              if (rw_q) begin
                tx_q   <= word_q;
                sda_oe <= ~word_q[WORD_W-1];
                state  <= ST_RD;
              end else begin
                sda_oe <= 1'b0;
                state  <= ST_WR;
              end
            end
          end
          ST_WR: begin
            if (scl_rise) begin
              shreg  <= {shreg[BYTE_W-2:0], sda_in};
              bitcnt <= bitcnt + 1'b1;
            end else if (byte_done) begin
              sda_oe <= 1'b1;
              state  <= ST_WR_ACK;
              if (!lo_phase) hi_q <= shreg[HI_KEEP-1:0];
            end
          end
          ST_WR_ACK: begin
            if (scl_rise && lo_phase) begin
              word_q <= {2'b00, hi_q, shreg};
              update <= 1'b1;
            end else if (scl_fall) begin
              sda_oe   <= 1'b0;
              bitcnt   <= '0;
              lo_phase <= ~lo_phase;
              state    <= ST_WR;
            end
          end
          ST_RD: begin
            if (scl_rise) begin
              bitcnt <= bitcnt + 1'b1;
            end else if (byte_done) begin
              sda_oe <= 1'b0;
              state  <= ST_RD_MACK;
            end else if (scl_fall) begin
              tx_q   <= {tx_q[WORD_W-2:0], 1'b0};
              sda_oe <= ~tx_q[WORD_W-2];
            end
          end
          ST_RD_MACK: begin
            if (scl_rise) begin
              mack_ok <= ~sda_in;
            end else if (scl_fall) begin
              if (mack_ok && !lo_phase) begin
                lo_phase <= 1'b1;
                bitcnt   <= '0;
                tx_q     <= {tx_q[WORD_W-2:0], 1'b0};
                sda_oe   <= ~tx_q[WORD_W-2];
                state    <= ST_RD;
              end else begin
                state <= ST_SKIP;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign code = word_q[CODE_W-1:0];
  assign pd   = word_q[CODE_W+PD_W-1:CODE_W];

endmodule

// File: rtl/i2c_dac_slave.sv
module i2c_dac_slave
  import i2cdac_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int VOTE_TAPS   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [6:0]        own_addr,
  output logic              sda_oe,
  output logic [CODE_W-1:0] dac_code,
  output logic [PD_W-1:0]   dac_pd,
  output logic              dac_update,
  output logic              hs_mode,
  output logic              addr_lock
);
  localparam int LINES = 2;

  logic [LINES-1:0] raw_lines, clean_lines;
  logic scl_rise, scl_fall, start_det, stop_det;

  assign raw_lines = {sda_i, scl_i};

  for (genvar g = 0; g < LINES; g++) begin : g_line
    i2cdac_deglitch #(
      .SYNC_STAGES(SYNC_STAGES),
      .VOTE_TAPS  (VOTE_TAPS)
    ) u_filt (
      .clk  (clk),
      .rst  (rst),
      .raw  (raw_lines[g]),
      .clean(clean_lines[g])
    );
  end

  i2cdac_bus_events u_events (
    .clk      (clk),
    .rst      (rst),
    .scl      (clean_lines[0]),
    .sda      (clean_lines[1]),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_det(start_det),
    .stop_det (stop_det)
  );

  i2cdac_engine u_engine (
    .clk       (clk),
    .rst       (rst),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .sda_in    (clean_lines[1]),
    .own_addr  (own_addr),
    .sda_oe    (sda_oe),
    .code      (dac_code),
    .pd        (dac_pd),
    .update    (dac_update),
    .hs_flag   (hs_mode),
    .lock_pulse(addr_lock)
  );

endmodule

// File: rtl/i2c_dac_slave_checker.sv
module i2c_dac_slave_checker (
  input logic        clk,
  input logic        rst,
  input logic        sda_oe,
  input logic [11:0] dac_code,
  input logic [1:0]  dac_pd,
  input logic        dac_update,
  input logic        addr_lock
);
  logic [1:0] lock_seen;

  always_ff @(posedge clk) begin
    if (rst) lock_seen <= '0;
    else if (addr_lock && lock_seen != 2'd3) lock_seen <= lock_seen + 2'd1;
  end

  assert_update_single_R2: assert property (@(posedge clk) disable iff (rst)
    dac_update |=> !dac_update);

  assert_code_needs_update_R2: assert property (@(posedge clk) disable iff (rst)
    (dac_code != $past(dac_code)) |-> dac_update);

  assert_pd_needs_update_R5: assert property (@(posedge clk) disable iff (rst)
    (dac_pd != $past(dac_pd)) |-> dac_update);

  assert_update_in_ack_R2: assert property (@(posedge clk) disable iff (rst)
    dac_update |-> sda_oe);

  assert_lock_single_R11: assert property (@(posedge clk) disable iff (rst)
    addr_lock |=> !addr_lock);

  assert_lock_once_R11: assert property (@(posedge clk) disable iff (rst)
    lock_seen <= 2'd1);

endmodule

bind i2c_dac_slave i2c_dac_slave_checker u_chk (
  .clk       (clk),
  .rst       (rst),
  .sda_oe    (sda_oe),
  .dac_code  (dac_code),
  .dac_pd    (dac_pd),
  .dac_update(dac_update),
  .addr_lock (addr_lock)
);

// File: tb/test_i2c_dac_slave.sv
module test_i2c_dac_slave;
  localparam int CLK_PERIOD = 10;
  localparam int HP = 20;
  localparam int Q  = HP / 2;
  localparam logic [6:0] OWN = 7'b0001101;
  localparam logic [6:0] BC  = 7'b1001000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, dac_update, hs_mode, addr_lock;
  logic [11:0] dac_code;
  logic [1:0]  dac_pd;
  logic sda_line;

  int errors = 0, checks = 0, lock_cnt = 0;
  logic [13:0] exp_q[$];
  bit done = 0;

  assign sda_line = sda_m & ~sda_oe;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_dac_slave i_i2c_dac_slave (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line), .own_addr(OWN),
    .sda_oe(sda_oe), .dac_code(dac_code), .dac_pd(dac_pd),
    .dac_update(dac_update), .hs_mode(hs_mode), .addr_lock(addr_lock)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // scoreboard monitor: every commit strobe must match the next expected word
  always @(negedge clk) begin
    if (!rst && dac_update) begin
      if (exp_q.size() == 0) check(1'b0, "R2 unexpected commit", {dac_pd, dac_code}, 0);
      else begin
        logic [13:0] e;
        e = exp_q.pop_front();
        check({dac_pd, dac_code} == e, "R2/R3 committed word", {dac_pd, dac_code}, e);
      end
    end
    if (!rst && addr_lock) lock_cnt++;
  end

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; waitc(Q);
    scl_m = 1'b1; waitc(HP);
    sda_m = 1'b0; waitc(HP);
    scl_m = 1'b0; waitc(Q);
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; waitc(Q);
    scl_m = 1'b1; waitc(HP);
    sda_m = 1'b1; waitc(HP);
  endtask

  task automatic put_bit(input logic b, input bit glitch);
    waitc(Q);
    sda_m = b; waitc(Q);
    scl_m = 1'b1;
    if (glitch) begin
      waitc(Q); scl_m = 1'b0; waitc(1); scl_m = 1'b1; waitc(HP - Q - 1);
    end else waitc(HP);
    scl_m = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, input int glitch_bit, output bit ack);
    for (int i = 7; i >= 0; i--) put_bit(b[i], (i == glitch_bit));
    waitc(Q);
    sda_m = 1'b1; waitc(Q);
    scl_m = 1'b1; waitc(Q);
    ack = (sda_line == 1'b0);
    waitc(Q);
    scl_m = 1'b0;
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      waitc(HP);
      scl_m = 1'b1; waitc(Q);
      b[i] = sda_line;
      waitc(Q);
      scl_m = 1'b0;
    end
    put_bit(give_ack ? 1'b0 : 1'b1, 1'b0);
    waitc(Q);
    sda_m = 1'b1;
  endtask

  task automatic write_words(input logic [6:0] a, input logic [15:0] w0, input logic [15:0] w1,
                             input bit two, input string req);
    bit ack;
    i2c_start();
    send_byte({a, 1'b0}, -1, ack);
    check(ack, {req, " address ack"}, ack, 1);
    exp_q.push_back({w0[13:12], w0[11:0]});
    send_byte(w0[15:8], -1, ack);
    check(ack, {req, " high byte ack"}, ack, 1);
    send_byte(w0[7:0], -1, ack);
    check(ack, {req, " low byte ack"}, ack, 1);
    if (two) begin
      exp_q.push_back({w1[13:12], w1[11:0]});
      send_byte(w1[15:8], -1, ack);
      send_byte(w1[7:0], -1, ack);
      check(ack, "R3 streamed pair ack", ack, 1);
    end
    i2c_stop();
  endtask

  task automatic read_word(output logic [15:0] w, output bit ack);
    logic [7:0] hi, lo;
    i2c_start();
    send_byte({OWN, 1'b1}, -1, ack);
    recv_byte(1'b1, hi);
    recv_byte(1'b0, lo);
    i2c_stop();
    w = {hi, lo};
  endtask

  initial begin
    waitc(CLK_PERIOD * 15000);
    if (!done) begin
      check(1'b0, "watchdog", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    bit ack;
    logic [15:0] rw;
    waitc(5);
    rst = 1'b0;
    waitc(5);
    // R8 reset state
    check(dac_code == 12'h000 && dac_pd == 2'b00, "R8 reset word", {dac_pd, dac_code}, 0);
    check(!sda_oe && !hs_mode, "R8 reset sda_oe/hs_mode", {sda_oe, hs_mode}, 0);

    // R1 foreign address NACKed, later bytes ignored
    i2c_start();
    send_byte({7'b0001110, 1'b0}, -1, ack);
    check(!ack, "R1 foreign address nack", ack, 0);
    send_byte(8'h0F, -1, ack);
    send_byte(8'hFF, -1, ack);
    check(!ack, "R1 ignored byte not acked", ack, 0);
    i2c_stop();
    check(dac_code == 12'h000, "R1 foreign write ignored", dac_code, 0);

    // R6 broadcast write, R11 no lock from broadcast
    write_words(BC, 16'h0123, 16'h0, 1'b0, "R6 broadcast");
    waitc(4);
    check(dac_code == 12'h123, "R6 broadcast commit", dac_code, 12'h123);
    check(lock_cnt == 0, "R11 no lock on broadcast", lock_cnt, 0);

    // R7 broadcast read NACK
    i2c_start();
    send_byte({BC, 1'b1}, -1, ack);
    check(!ack, "R7 broadcast read nack", ack, 0);
    waitc(HP);
    check(!sda_oe, "R7 no drive on broadcast read", sda_oe, 0);
    i2c_stop();

    // R2 high byte alone does not commit; R11 lock pulse on first own ack
    i2c_start();
    send_byte({OWN, 1'b0}, -1, ack);
    check(ack, "R1 own address ack", ack, 1);
    check(lock_cnt == 1, "R11 lock pulse on first own ack", lock_cnt, 1);
    send_byte(8'h0A, -1, ack);
    waitc(HP);
    check(dac_code == 12'h123, "R2 no commit after high byte", dac_code, 12'h123);
    exp_q.push_back({2'b00, 12'hABC});
    send_byte(8'hBC, -1, ack);
    // R3 stream a second pair
    exp_q.push_back({2'b00, 12'h555});
    send_byte(8'h05, -1, ack);
    send_byte(8'h55, -1, ack);
    check(ack, "R3 second pair low ack", ack, 1);
    i2c_stop();
    check(dac_code == 12'h555, "R3 last streamed word", dac_code, 12'h555);

    // R4 read back
    read_word(rw, ack);
    check(ack, "R4 read address ack", ack, 1);
    check(rw == 16'h0555, "R4 read back word", rw, 16'h0555);
    waitc(2);
    check(!sda_oe, "R4 released after nack", sda_oe, 0);

    // R5/R8 top bits forced zero, power-down field, code kept readable
    write_words(OWN, 16'hE7FF, 16'h0, 1'b0, "R5 write");
    waitc(4);
    check(dac_pd == 2'b10 && dac_code == 12'h7FF, "R5 pd and code fields", {dac_pd, dac_code}, 14'h27FF);
    read_word(rw, ack);
    check(rw == 16'h27FF, "R5/R8 readback with top bits zero in power-down", rw, 16'h27FF);

    // R10 Start mid-byte aborts
    i2c_start();
    send_byte({OWN, 1'b0}, -1, ack);
    send_byte(8'h01, -1, ack);
    for (int i = 0; i < 4; i++) put_bit(1'b1, 1'b0);
    i2c_start();
    i2c_stop();
    waitc(4);
    check(dac_code == 12'h7FF && dac_pd == 2'b10, "R10 aborted word not committed",
          {dac_pd, dac_code}, 14'h27FF);
    write_words(OWN, 16'h0321, 16'h0, 1'b0, "R10 recovery");
    waitc(4);
    check(dac_code == 12'h321 && dac_pd == 2'b00, "R10 recovery commit", {dac_pd, dac_code}, 14'h0321);

    // R12 one-clock SCL glitch in the high byte
    i2c_start();
    send_byte({OWN, 1'b0}, -1, ack);
    exp_q.push_back({2'b00, 12'hACE});
    send_byte(8'h0A, 3, ack);
    send_byte(8'hCE, -1, ack);
    i2c_stop();
    waitc(4);
    check(dac_code == 12'hACE, "R12 glitch rejected", dac_code, 12'hACE);

    // R9 high-speed preamble
    i2c_start();
    send_byte(8'h0B, -1, ack);
    check(!ack, "R9 master code nack", ack, 0);
    check(!hs_mode, "R9 flag not yet set", hs_mode, 0);
    i2c_start();
    waitc(4);
    check(hs_mode, "R9 flag set on repeated start", hs_mode, 1);
    send_byte({OWN, 1'b0}, -1, ack);
    exp_q.push_back({2'b00, 12'hFFF});
    send_byte(8'h0F, -1, ack);
    send_byte(8'hFF, -1, ack);
    i2c_start();
    waitc(4);
    check(hs_mode, "R9 flag kept across repeated start", hs_mode, 1);
    i2c_stop();
    waitc(4);
    check(!hs_mode, "R9 flag cleared by stop", hs_mode, 0);
    check(dac_code == 12'hFFF, "R9 write in high-speed mode", dac_code, 12'hFFF);

    waitc(20);
    check(exp_q.size() == 0, "R2 all expected commits seen", exp_q.size(), 0);
    check(lock_cnt == 1, "R11 single lock pulse overall", lock_cnt, 1);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule